// File: doc/BRIEF.md
# Dual-Speed Peripheral Clock-Enable Generator

This block generates the timing strobes that pace the CPU and four peripherals of a small microcontroller. Every strobe is a single oscillator-clock pulse. All of them come from one shared free-running divider, so nothing is ever clock-gated. An 8-bit control register on the special-function-register bus chooses the timing:

- One global bit switches the machine from standard timing (12 oscillator periods per cycle) to double-speed timing (6 periods per cycle).
- While double speed is active, each peripheral has its own bit that puts it back to the 12-period rate. For a peripheral bit, a set bit means slow.

The peripherals are timer 0, timer 1, the watchdog and the serial port. The serial-port strobe is meant only for the synchronous mode and the fixed-rate mode of that port. The 6-period strobe is a superset of the 12-period strobe, so every slow strobe falls on a fast one. A channel adopts a new rate only on one of its own strobe edges. Because of this, a mode change never produces a shortened or stretched cycle.

Top module: `pcs_strobe_gen`

## Requirements
- R1: While reset is high, and right after it, every strobe is low and the read data is 0. After reset the control register reads 0x00.
- R2: A write at address 0x8F stores bits 0, 1, 2, 3 and 5. Bits 4, 6 and 7 always read 0, so writing 0xFF reads back as 0x2F. Read data is registered and appears one clock after the address is presented.
- R3: A read at any address other than 0x8F returns 0. A write to any other address leaves the control register and all strobe rates unchanged.
- R4: While bit 0 is 0, the CPU strobe and all four peripheral strobes repeat every 12 clocks, whatever the values of bits 1, 2, 3 and 5.
- R5: While bit 0 is 1, the CPU strobe repeats every 6 clocks.
- R6: While bit 0 is 1, a peripheral repeats every 6 clocks if its bit is 0 and every 12 clocks if its bit is 1. The bits are: timer 0 on bit 1, timer 1 on bit 2, serial port on bit 3, watchdog on bit 5.
- R7: Every strobe is high for exactly one clock per pulse.
- R8: Whenever any peripheral strobe is high, the CPU strobe is high in the same clock.
- R9: Across any sequence of register writes, the spacing between two pulses of the same strobe is always exactly 6 or exactly 12 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Register bus write enable |
| sfr_rdata | output | 8 | Registered read data |
| cpu_stb | output | 1 | Machine-cycle enable |
| tmr0_stb | output | 1 | Timer 0 enable |
| tmr1_stb | output | 1 | Timer 1 enable |
| ser_stb | output | 1 | Serial-port enable for its synchronous and fixed-rate modes |
| wdt_stb | output | 1 | Watchdog enable |

## Verification
The hardest case to reach is a rate change that lands in the middle of a slow period, where a naive design would emit a 6- or 18-clock gap. The same risk applies to a fast channel whose latch edge falls on the half-period tick instead of the wrap tick. The stimulus reaches these cases by writing the control register at phases that are not tied to the divider. It writes in turn the global bit, each individual peripheral bit and a mix of bits, so that changes fall on both tick positions. Meanwhile a monitor measures every single inter-pulse gap and every coincidence of strobes. Once each configuration has settled, a scoreboard compares the measured periods of all five strobes against the values expected from the written register.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam logic [7:0] CTL_ADDR_DEF = 8'h8F;
  localparam logic [7:0] CTL_MASK_DEF = 8'h2F;
  localparam int BIT_X2    = 0;
  localparam int N_PERIPH  = 4;

  // peripheral channel index -> control bit position
  function automatic int periph_bit(input int idx);
    case (idx)
      0:       return 1;  // timer 0
      1:       return 2;  // timer 1
      2:       return 3;  // serial port
      default: return 5;  // watchdog
    endcase
  endfunction
endpackage

// File: rtl/pcs_sfr.sv
module pcs_sfr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h8F,
  parameter logic [DATA_W-1:0] CTL_MASK = 8'h2F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctl
);
  logic hit;
  assign hit = (addr == CTL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      rdata <= '0;
    end else begin
      if (we && hit) ctl <= wdata & CTL_MASK;
      rdata <= hit ? ctl : '0;
    end
  end
endmodule

// File: rtl/pcs_div.sv
module pcs_div #(
  parameter int SLOW_DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic fast_tick,
  output logic slow_tick
);
  localparam int FAST_DIV = SLOW_DIV / 2;
  localparam int CW       = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(FAST_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign slow_tick = (cnt == LAST);
  assign fast_tick = slow_tick || (cnt == MID);
endmodule

// File: rtl/pcs_chan.sv
module pcs_chan (
  input  logic clk,
  input  logic rst,
  input  logic fast_tick,
  input  logic slow_tick,
  input  logic want_slow,
  output logic stb
);
  logic slow_q;
  logic tick;

  assign tick = slow_q ? slow_tick : fast_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_q <= 1'b1;
      stb    <= 1'b0;
    end else begin
      stb <= tick;
      if (tick) slow_q <= want_slow;
    end
  end
endmodule

// File: rtl/pcs_strobe_gen.sv
module pcs_strobe_gen #(
  parameter int SLOW_DIV = 12,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = pcs_pkg::CTL_ADDR_DEF,
  parameter logic [DATA_W-1:0] CTL_MASK = pcs_pkg::CTL_MASK_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              cpu_stb,
  output logic              tmr0_stb,
  output logic              tmr1_stb,
  output logic              ser_stb,
  output logic              wdt_stb
);
  localparam int NP = pcs_pkg::N_PERIPH;

  logic [DATA_W-1:0] ctl_q;
  logic              fast_tick, slow_tick;
  logic [NP-1:0]     periph_stb;
  logic              std_mode;

  pcs_sfr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTL_ADDR(CTL_ADDR), .CTL_MASK(CTL_MASK)
  ) u_sfr (
    .clk(clk), .rst(rst), .addr(sfr_addr), .wdata(sfr_wdata),
    .we(sfr_we), .rdata(sfr_rdata), .ctl(ctl_q)
  );

  pcs_div #(.SLOW_DIV(SLOW_DIV)) u_div (
    .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick)
  );

  assign std_mode = ~ctl_q[pcs_pkg::BIT_X2];

  pcs_chan u_cpu (
    .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .want_slow(std_mode), .stb(cpu_stb)
  );

  for (genvar i = 0; i < NP; i++) begin : g_periph
    localparam int BITPOS = pcs_pkg::periph_bit(i);
    pcs_chan u_ch (
      .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick),
      .want_slow(std_mode | ctl_q[BITPOS]), .stb(periph_stb[i])
    );
  end

  assign tmr0_stb = periph_stb[0];
  assign tmr1_stb = periph_stb[1];
  assign ser_stb  = periph_stb[2];
  assign wdt_stb  = periph_stb[3];
endmodule

// File: rtl/pcs_strobe_chk.sv
module pcs_strobe_chk #(
  parameter int SLOW_DIV = 12,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = pcs_pkg::CTL_ADDR_DEF,
  parameter logic [DATA_W-1:0] CTL_MASK = pcs_pkg::CTL_MASK_DEF
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_we,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic [DATA_W-1:0] ctl,
  input logic              cpu_stb,
  input logic [pcs_pkg::N_PERIPH-1:0] periph_stb
);
  localparam int NS = pcs_pkg::N_PERIPH + 1;
  localparam int GW = $clog2(4 * SLOW_DIV);
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};
  localparam logic [GW-1:0] G_FAST = GW'(SLOW_DIV / 2);
  localparam logic [GW-1:0] G_SLOW = GW'(SLOW_DIV);

  logic [NS-1:0] all_stb;
  assign all_stb = {periph_stb, cpu_stb};

  logic [GW-1:0] std_age;
  always_ff @(posedge clk) begin
    if (rst || ctl[pcs_pkg::BIT_X2]) std_age <= '0;
    else if (std_age != GMAX)        std_age <= std_age + 1'b1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (sfr_rdata == '0 && all_stb == '0));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_rdata & ~CTL_MASK) == '0);

  // R3
  foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_we && sfr_addr != CTL_ADDR) |=> (ctl == $past(ctl)));

  // R8
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (|periph_stb) |-> cpu_stb);

  for (genvar i = 0; i < NS; i++) begin : g_stb
    logic [GW-1:0] gap;
    logic          seen;
    always_ff @(posedge clk) begin
      if (rst) begin
        gap  <= '0;
        seen <= 1'b0;
      end else if (all_stb[i]) begin
        gap  <= GW'(1);
        seen <= 1'b1;
      end else if (gap != GMAX) begin
        gap  <= gap + 1'b1;
      end
    end

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      all_stb[i] |=> !all_stb[i]);

    // R9
    gap_legal_chk: assert property (@(posedge clk) disable iff (rst)
      (all_stb[i] && seen) |-> (gap == G_FAST || gap == G_SLOW));

    // R4
    std_rate_chk: assert property (@(posedge clk) disable iff (rst)
      (all_stb[i] && seen && std_age > GW'(2 * SLOW_DIV)) |-> (gap == G_SLOW));
  end
endmodule

bind pcs_strobe_gen pcs_strobe_chk #(
  .SLOW_DIV(SLOW_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CTL_ADDR(CTL_ADDR), .CTL_MASK(CTL_MASK)
) u_chk (
  .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
  .sfr_rdata(sfr_rdata), .ctl(ctl_q), .cpu_stb(cpu_stb),
  .periph_stb(periph_stb)
);

// File: tb/pcs_strobe_gen_bench.sv
module pcs_strobe_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = 8'h8F;
  logic [7:0] sfr_wdata = 8'h00;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic       cpu_stb, tmr0_stb, tmr1_stb, ser_stb, wdt_stb;

  always #2 clk = ~clk;  // 250 MHz

  pcs_strobe_gen u_pcs_strobe_gen (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .cpu_stb(cpu_stb),
    .tmr0_stb(tmr0_stb), .tmr1_stb(tmr1_stb), .ser_stb(ser_stb),
    .wdt_stb(wdt_stb)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    int    ch;
    int    period;
    string req;
  } exp_t;
  exp_t sb_q[$];

  // channel order: 0 cpu, 1 tmr0, 2 tmr1, 3 serial, 4 watchdog
  logic [4:0] stbv;
  assign stbv = {wdt_stb, ser_stb, tmr1_stb, tmr0_stb, cpu_stb};

  int   cnt [5];
  int   last_gap [5];
  bit   seen [5];
  logic [4:0] prev_stbv = '0;
  int   bad_gap = 0;
  int   bad_width = 0;
  int   bad_align = 0;
  bit   mon_on = 1'b0;

  // monitor: measures gaps and pops the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < 5; i++) begin
        if (stbv[i]) begin
          if (seen[i]) begin
            last_gap[i] = cnt[i];
            if (cnt[i] != 6 && cnt[i] != 12) bad_gap++;
          end
          seen[i] = 1'b1;
          cnt[i]  = 1;
        end else begin
          cnt[i] = cnt[i] + 1;
        end
        if (stbv[i] && prev_stbv[i]) bad_width++;
      end
      if ((|stbv[4:1]) && !stbv[0]) bad_align++;
      prev_stbv = stbv;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (last_gap[e.ch] != e.period) begin
          errors++;
          $display("FAIL %s channel %0d period actual %0d expected %0d",
                   e.req, e.ch, last_gap[e.ch], e.period);
        end
      end
    end
  end

  task automatic check_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0; sfr_addr = 8'h8F;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    @(negedge clk);
    d = sfr_rdata;
    sfr_addr = 8'h8F;
  endtask

  task automatic expect_rates(input int c, input int t0, input int t1,
                              input int se, input int wd, input string req);
    repeat (40) @(negedge clk);
    sb_q.push_back('{0, c,  req});
    sb_q.push_back('{1, t0, req});
    sb_q.push_back('{2, t1, req});
    sb_q.push_back('{3, se, req});
    sb_q.push_back('{4, wd, req});
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic set_and_expect(input logic [7:0] v, input int skew,
                                input int c, input int t0, input int t1,
                                input int se, input int wd, input string req);
    repeat (skew) @(negedge clk);
    sfr_write(8'h8F, v);
    expect_rates(c, t0, t1, se, wd, req);
  endtask

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 5; i++) begin
      cnt[i] = 0; last_gap[i] = 0; seen[i] = 1'b0;
    end
    repeat (5) @(negedge clk);
    // R1: quiet during reset
    check_val("R1 strobes in reset", int'(stbv), 0);
    check_val("R1 rdata in reset", int'(sfr_rdata), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    sfr_read(8'h8F, rd);
    check_val("R1 reset value", int'(rd), 8'h00);

    // R4: standard timing from reset
    expect_rates(12, 12, 12, 12, 12, "R4 reset standard");
    // R4: peripheral bits ignored while global clear
    set_and_expect(8'h2E, 3, 12, 12, 12, 12, 12, "R4 bits ignored");
    sfr_read(8'h8F, rd);
    check_val("R2 readback 2E", int'(rd), 8'h2E);
    // R2: reserved bits dropped
    sfr_write(8'h8F, 8'hFF);
    sfr_read(8'h8F, rd);
    check_val("R2 reserved read 0", int'(rd), 8'h2F);

    // R5 R6: double speed, all fast
    set_and_expect(8'h01, 1, 6, 6, 6, 6, 6, "R5 R6 all fast");
    set_and_expect(8'h03, 4, 6, 12, 6, 6, 6, "R6 timer0 slow");
    set_and_expect(8'h05, 7, 6, 6, 12, 6, 6, "R6 timer1 slow");
    set_and_expect(8'h09, 2, 6, 6, 6, 12, 6, "R6 serial slow");
    set_and_expect(8'h21, 9, 6, 6, 6, 6, 12, "R6 watchdog slow");
    set_and_expect(8'h2F, 5, 6, 12, 12, 12, 12, "R6 all periph slow");
    set_and_expect(8'h13, 0, 6, 12, 6, 6, 6, "R6 reserved bit4 no effect");

    // R3: foreign address writes and reads
    sfr_write(8'h8F, 8'h2F);
    sfr_write(8'h8E, 8'h00);
    sfr_write(8'h90, 8'h01);
    sfr_read(8'h8F, rd);
    check_val("R3 foreign write kept reg", int'(rd), 8'h2F);
    sfr_read(8'h8E, rd);
    check_val("R3 foreign read zero", int'(rd), 8'h00);
    sfr_read(8'h00, rd);
    check_val("R3 foreign read zero at 00", int'(rd), 8'h00);
    expect_rates(6, 12, 12, 12, 12, "R3 rates unchanged");

    // back to standard from mixed, at odd phases
    set_and_expect(8'h0A, 11, 12, 12, 12, 12, 12, "R4 return standard");
    set_and_expect(8'h01, 6, 6, 6, 6, 6, 6, "R5 double again");
    // rapid toggling across phases (R9 stress)
    for (int k = 0; k < 24; k++) begin
      sfr_write(8'h8F, (k % 2 == 0) ? 8'h00 : 8'h01);
      repeat (k % 7) @(negedge clk);
    end
    set_and_expect(8'h00, 2, 12, 12, 12, 12, 12, "R4 after toggling");

    check_val("R7 single-cycle pulses", bad_width, 0);
    check_val("R8 peripheral on cpu strobe", bad_align, 0);
    check_val("R9 gaps only 6 or 12", bad_gap, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule